// File: doc/BRIEF.md
# Instruction Fetch Address Translator

This block converts the address of an instruction fetch into a physical address and produces a fault code. The fetch address enters with a strobe, the current privilege mode, the address-space number and a physical-mode flag. In the same cycle the block sends the page number and the address-space number to an attached lookup table. It takes back that table's hit flag, its physical page number and its per-mode execute mask. The result comes out one clock later. It holds the physical address, a two-bit fault code and an uncacheable flag.

Four address kinds are handled, in priority order:
- A fetch address with bit 0 set marks privileged code and skips translation.
- Physical mode passes the address through.
- A kernel-only direct-map window maps a fixed virtual region straight onto physical space.
- All other addresses go through the page table entry returned by the lookup table.

Non-canonical virtual addresses are rejected. Physical addresses that do not fit the implemented width raise a machine check. An address in the uncached region is flagged and has its bits 42:35 cleared.

Filling the lookup table and storing its entries are handled outside this block.

Top module: `ifetch_xlate`

## Requirements
- R1: A response appears exactly one clock after each request. `rsp_vld` is high for one cycle per request cycle. While `req_vld` is low, `rsp_pa`, `rsp_fault` and `rsp_uncached` keep their last values.
- R2: When `req_va[0]` is 1, translation is skipped, whatever the other inputs are. The response is `rsp_pa = req_va & ~3 & (2^44-1)`, fault code 0 (none) and `rsp_uncached = 0`.
- R3: When `req_va[0]` is 0 and `req_phys` is 1, the physical address equals `req_va`. This path has no canonical check and no permission check.
- R4: In virtual mode, the address is non-canonical when `req_va[63:47]` are not all equal. A non-canonical address gives fault code 1 (access violation) with `rsp_pa = 0`.
- R5: A canonical virtual address with `req_va[47:41] = 7'h7E` is a direct-map access. Any mode other than 0 (kernel) gives fault code 1. In kernel mode the block forms the physical address from `req_va[43:0]`:
  - If bit 40 of that value is 1, bits 43:40 are forced to 4'hF.
  - Otherwise the value is cut to its low 40 bits.
- R6: Every other canonical virtual address is looked up. The block drives `tlb_vpn = req_va[47:13]` and passes `req_asn` to `tlb_asn` in the same cycle. If `tlb_hit` is 0, the response is fault code 2 (page miss) with `rsp_pa = 0`.
- R7: On a lookup hit, the physical address is `(tlb_ppn << 13) + {req_va[12:2], 2'b00}`.
- R8: A lookup hit gives fault code 1 with `rsp_pa = 0` unless bit `req_mode` of `tlb_xre` is 1. Mode codes are 0 kernel, 1 executive, 2 supervisor and 3 user. A page miss takes priority over this check.
- R9: On the physical, direct-map and mapped paths, a physical address with any bit at position 44 or above set gives fault code 3 (machine check). In that case `rsp_pa` carries the unmodified physical address and `rsp_uncached` is 0.
- R10: On the physical, direct-map and mapped paths, an address that has not faulted and has bit 43 set is uncached. For such an address, `rsp_uncached` is 1 and `rsp_pa` is that address with bits 42:35 cleared. Otherwise `rsp_uncached` is 0, and any fault also forces it to 0.
- R11: While `rst_n` is low, `rsp_vld`, `rsp_pa`, `rsp_fault` and `rsp_uncached` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_vld | input | 1 | Request strobe |
| req_va | input | 64 | Fetch address |
| req_phys | input | 1 | Physical-mode flag |
| req_mode | input | 2 | Current privilege mode (0 kernel to 3 user) |
| req_asn | input | 8 | Current address-space number |
| tlb_vpn | output | 35 | Page number sent to the lookup table |
| tlb_asn | output | 8 | Address-space number sent to the lookup table |
| tlb_hit | input | 1 | Lookup table hit |
| tlb_ppn | input | 32 | Physical page number of the hit |
| tlb_xre | input | 4 | Execute-enable mask of the hit, one bit per mode |
| rsp_vld | output | 1 | Response strobe |
| rsp_pa | output | 64 | Translated physical address |
| rsp_fault | output | 2 | Fault code: 0 none, 1 access violation, 2 page miss, 3 machine check |
| rsp_uncached | output | 1 | Access is uncacheable |

## Verification
The only state is the response register, so an internal fault shows on the ports one clock after the request that caused it. There is no delayed symptom to hunt for. A mis-prioritised region decode appears on the first request whose address sits on two paths at once. Examples are an odd address in the direct-map window, and a page miss combined with a cleared execute bit. A wrong hold enable shows as a change on `rsp_pa` during the first idle cycle. For this reason the bench compares every output against a behavioural model on every clock, including idle clocks.

// File: rtl/ixl_pkg.sv
package ixl_pkg;

    parameter int unsigned ADDR_W = 64;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_ACV  = 2'd1,
        FLT_MISS = 2'd2,
        FLT_MCHK = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        MD_KERNEL = 2'd0,
        MD_EXEC   = 2'd1,
        MD_SUPER  = 2'd2,
        MD_USER   = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        RG_BYPASS,
        RG_PHYS,
        RG_BADVA,
        RG_DIRECT,
        RG_MAPPED
    } region_e;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] pa;
        fault_e            fault;
        logic              unc;
    } rsp_t;

endpackage

// File: rtl/ixl_region.sv
module ixl_region
    import ixl_pkg::*;
#(
    parameter int unsigned HI_W   = 17,
    parameter int unsigned WIN_W  = 7,
    parameter logic [WIN_W-1:0] WIN_TAG = 7'h7E
) (
    input  logic             pal_bit,
    input  logic             phys,
    input  logic [HI_W-1:0]  va_hi,
    input  logic [WIN_W-1:0] va_win,
    output region_e          region
);
    logic canonical;

    always_comb begin
        canonical = (&va_hi) | ~(|va_hi);
        if (pal_bit)
            region = RG_BYPASS;
        else if (phys)
            region = RG_PHYS;
        else if (!canonical)
            region = RG_BADVA;
        else if (va_win == WIN_TAG)
            region = RG_DIRECT;
        else
            region = RG_MAPPED;
    end
endmodule

// File: rtl/ixl_direct.sv
module ixl_direct
    import ixl_pkg::*;
#(
    parameter int unsigned PA_W    = 44,
    parameter int unsigned EXT_BIT = 40
) (
    input  logic [PA_W-1:0]   va_lo,
    output logic [ADDR_W-1:0] pa
);
    localparam int unsigned FILL_W = PA_W - EXT_BIT;

    always_comb begin
        pa = '0;
        pa[EXT_BIT-1:0] = va_lo[EXT_BIT-1:0];
        if (va_lo[EXT_BIT])
            pa[PA_W-1:EXT_BIT] = {FILL_W{1'b1}};
    end
endmodule

// File: rtl/ixl_pagemap.sv
module ixl_pagemap
    import ixl_pkg::*;
#(
    parameter int unsigned PPN_W      = 32,
    parameter int unsigned PAGE_SHIFT = 13,
    parameter int unsigned MODE_W     = 2,
    parameter int unsigned ALIGN_BITS = 2
) (
    input  logic [PAGE_SHIFT-1:ALIGN_BITS] va_off,
    input  logic                          hit,
    input  logic [PPN_W-1:0]              ppn,
    input  logic [(1<<MODE_W)-1:0]        xre,
    input  logic [MODE_W-1:0]             mode,
    output logic                          miss,
    output logic                          perm_ok,
    output logic [ADDR_W-1:0]             pa
);
    localparam int unsigned NMODES = 1 << MODE_W;

    logic [NMODES-1:0] mode_sel;

    generate
        for (genvar m = 0; m < NMODES; m++) begin : g_sel
            assign mode_sel[m] = (mode == MODE_W'(m)) & xre[m];
        end
    endgenerate

    always_comb begin
        miss    = ~hit;
        perm_ok = |mode_sel;
        pa      = (ADDR_W'(ppn) << PAGE_SHIFT)
                + ADDR_W'({va_off, {ALIGN_BITS{1'b0}}});
    end
endmodule

// File: rtl/ixl_finish.sv
module ixl_finish
    import ixl_pkg::*;
#(
    parameter int unsigned PA_W   = 44,
    parameter int unsigned UNC_BIT = 43,
    parameter int unsigned CLR_HI = 42,
    parameter int unsigned CLR_LO = 35
) (
    input  logic [ADDR_W-1:0] pa_in,
    output logic              mchk,
    output logic              unc,
    output logic [ADDR_W-1:0] pa_out
);
    localparam logic [ADDR_W-1:0] CLR_MASK =
        ((ADDR_W'(1) << (CLR_HI + 1)) - ADDR_W'(1)) ^ ((ADDR_W'(1) << CLR_LO) - ADDR_W'(1));

    always_comb begin
        mchk   = |pa_in[ADDR_W-1:PA_W];
        unc    = ~mchk & pa_in[UNC_BIT];
        pa_out = unc ? (pa_in & ~CLR_MASK) : pa_in;
    end
endmodule

// File: rtl/ifetch_xlate.sv
module ifetch_xlate
    import ixl_pkg::*;
#(
    parameter int unsigned PA_W       = 44,
    parameter int unsigned VA_IMPL    = 48,
    parameter int unsigned PAGE_SHIFT = 13,
    parameter int unsigned PPN_W      = 32,
    parameter int unsigned ASN_W      = 8,
    parameter int unsigned MODE_W     = 2,
    parameter int unsigned WIN_LO     = 41,
    parameter int unsigned EXT_BIT    = 40,
    parameter int unsigned UNC_BIT    = 43,
    parameter int unsigned CLR_HI     = 42,
    parameter int unsigned CLR_LO     = 35
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_vld,
    input  logic [63:0]                   req_va,
    input  logic                          req_phys,
    input  logic [MODE_W-1:0]             req_mode,
    input  logic [ASN_W-1:0]              req_asn,
    output logic [VA_IMPL-PAGE_SHIFT-1:0] tlb_vpn,
    output logic [ASN_W-1:0]              tlb_asn,
    input  logic                          tlb_hit,
    input  logic [PPN_W-1:0]              tlb_ppn,
    input  logic [(1<<MODE_W)-1:0]        tlb_xre,
    output logic                          rsp_vld,
    output logic [63:0]                   rsp_pa,
    output logic [1:0]                    rsp_fault,
    output logic                          rsp_uncached
);
    localparam int unsigned HI_W  = ADDR_W - VA_IMPL + 1;
    localparam int unsigned WIN_W = VA_IMPL - WIN_LO;
    localparam logic [ADDR_W-1:0] IMPL_MASK = (ADDR_W'(1) << PA_W) - ADDR_W'(1);
    localparam logic [ADDR_W-1:0] PAL_MASK  = ~ADDR_W'(3);

    region_e           region;
    logic [ADDR_W-1:0] direct_pa, map_pa, fin_in, fin_pa;
    logic              map_miss, map_perm_ok, fin_mchk, fin_unc;
    rsp_t              rsp_d, rsp_q;

    assign tlb_vpn = req_va[VA_IMPL-1:PAGE_SHIFT];
    assign tlb_asn = req_asn;

    ixl_region #(.HI_W(HI_W), .WIN_W(WIN_W), .WIN_TAG(7'h7E)) u_region (
        .pal_bit (req_va[0]),
        .phys    (req_phys),
        .va_hi   (req_va[ADDR_W-1:VA_IMPL-1]),
        .va_win  (req_va[VA_IMPL-1:WIN_LO]),
        .region  (region)
    );

    ixl_direct #(.PA_W(PA_W), .EXT_BIT(EXT_BIT)) u_direct (
        .va_lo (req_va[PA_W-1:0]),
        .pa    (direct_pa)
    );

    ixl_pagemap #(.PPN_W(PPN_W), .PAGE_SHIFT(PAGE_SHIFT), .MODE_W(MODE_W), .ALIGN_BITS(2)) u_pagemap (
        .va_off  (req_va[PAGE_SHIFT-1:2]),
        .hit     (tlb_hit),
        .ppn     (tlb_ppn),
        .xre     (tlb_xre),
        .mode    (req_mode),
        .miss    (map_miss),
        .perm_ok (map_perm_ok),
        .pa      (map_pa)
    );

    always_comb begin
        case (region)
            RG_PHYS:   fin_in = req_va;
            RG_DIRECT: fin_in = direct_pa;
            default:   fin_in = map_pa;
        endcase
    end

    ixl_finish #(.PA_W(PA_W), .UNC_BIT(UNC_BIT), .CLR_HI(CLR_HI), .CLR_LO(CLR_LO)) u_finish (
        .pa_in  (fin_in),
        .mchk   (fin_mchk),
        .unc    (fin_unc),
        .pa_out (fin_pa)
    );

    always_comb begin
        logic take_fin;
        rsp_d     = rsp_q;
        rsp_d.vld = req_vld;
        take_fin  = 1'b0;
        if (req_vld) begin
            rsp_d.pa    = '0;
            rsp_d.fault = FLT_NONE;
            rsp_d.unc   = 1'b0;
            case (region)
                RG_BYPASS: rsp_d.pa = req_va & PAL_MASK & IMPL_MASK;
                RG_BADVA:  rsp_d.fault = FLT_ACV;
                RG_PHYS:   take_fin = 1'b1;
                RG_DIRECT: begin
                    if (req_mode != MODE_W'(MD_KERNEL))
                        rsp_d.fault = FLT_ACV;
                    else
                        take_fin = 1'b1;
                end
                default: begin
                    if (map_miss)
                        rsp_d.fault = FLT_MISS;
                    else if (!map_perm_ok)
                        rsp_d.fault = FLT_ACV;
                    else
                        take_fin = 1'b1;
                end
            endcase
            if (take_fin) begin
                if (fin_mchk) begin
                    rsp_d.fault = FLT_MCHK;
                    rsp_d.pa    = fin_in;
                end else begin
                    rsp_d.pa  = fin_pa;
                    rsp_d.unc = fin_unc;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rsp_q <= '0;
        else
            rsp_q <= rsp_d;
    end

    assign rsp_vld      = rsp_q.vld;
    assign rsp_pa       = rsp_q.pa;
    assign rsp_fault    = rsp_q.fault;
    assign rsp_uncached = rsp_q.unc;

    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> rsp_vld);
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> (!rsp_vld && $stable(rsp_pa) && $stable(rsp_fault)));
    p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_va[0]) |=> (rsp_fault == FLT_NONE && rsp_pa[1:0] == 2'b00
                                    && !rsp_uncached && rsp_pa[63:PA_W] == '0));
    p_badva_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !req_va[0] && !req_phys && (req_va[63] != req_va[VA_IMPL-1]))
            |=> (rsp_fault == FLT_ACV));
    p_miss_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && (rsp_fault == FLT_ACV || rsp_fault == FLT_MISS)) |-> (rsp_pa == '0));
    p_mchk_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && rsp_fault == FLT_MCHK) |-> (rsp_pa[63:PA_W] != '0 && !rsp_uncached));
    p_uncached_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_uncached |-> (rsp_fault == FLT_NONE && rsp_pa[UNC_BIT] && rsp_pa[CLR_HI:CLR_LO] == '0));
endmodule

// File: tb/ifetch_xlate_test.sv
`timescale 1ns/1ps
module ifetch_xlate_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0;
    logic [63:0] req_va = '0;
    logic        req_phys = 1'b0;
    logic [1:0]  req_mode = '0;
    logic [7:0]  req_asn = '0;
    logic [34:0] tlb_vpn;
    logic [7:0]  tlb_asn;
    logic        tlb_hit = 1'b0;
    logic [31:0] tlb_ppn = '0;
    logic [3:0]  tlb_xre = '0;
    logic        rsp_vld;
    logic [63:0] rsp_pa;
    logic [1:0]  rsp_fault;
    logic        rsp_uncached;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [63:0] exp_pa = '0;
    logic [1:0]  exp_fault = '0;
    logic        exp_unc = 1'b0;

    always #2 clk = ~clk;

    ifetch_xlate uut (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_va(req_va),
        .req_phys(req_phys), .req_mode(req_mode), .req_asn(req_asn),
        .tlb_vpn(tlb_vpn), .tlb_asn(tlb_asn), .tlb_hit(tlb_hit),
        .tlb_ppn(tlb_ppn), .tlb_xre(tlb_xre), .rsp_vld(rsp_vld),
        .rsp_pa(rsp_pa), .rsp_fault(rsp_fault), .rsp_uncached(rsp_uncached)
    );

    // Behavioural reference: final address post-processing (R9, R10)
    task automatic settle(input logic [63:0] a);
        if (a >= 64'h1000_0000_0000) begin
            exp_fault = 2'd3; exp_pa = a; exp_unc = 1'b0;
        end else if (a[43]) begin
            exp_pa = a;
            for (int b = 35; b <= 42; b++) exp_pa[b] = 1'b0;
            exp_unc = 1'b1; exp_fault = 2'd0;
        end else begin
            exp_pa = a; exp_unc = 1'b0; exp_fault = 2'd0;
        end
    endtask

    task automatic model(input logic [63:0] va, input logic ph, input logic [1:0] md,
                         input logic h, input logic [31:0] pp, input logic [3:0] xr);
        logic [63:0] t;
        exp_pa = '0; exp_fault = 2'd0; exp_unc = 1'b0;
        if (va[0]) begin
            exp_pa = {20'd0, va[43:2], 2'b00};
        end else if (ph) begin
            settle(va);
        end else if (!(va[63:47] == 17'h0 || va[63:47] == 17'h1FFFF)) begin
            exp_fault = 2'd1;
        end else if (va[47:41] == 7'h7E) begin
            if (md != 2'd0) exp_fault = 2'd1;
            else begin
                t = va[40] ? {20'd0, 4'hF, va[39:0]} : {24'd0, va[39:0]};
                settle(t);
            end
        end else if (!h) begin
            exp_fault = 2'd2;
        end else if (!xr[md]) begin
            exp_fault = 2'd1;
        end else begin
            t = {32'd0, pp} * 64'd8192 + {51'd0, va[12:2], 2'b00};
            settle(t);
        end
    endtask

    task automatic compare(input string tag, input logic vld_exp);
        checks++;
        if (rsp_vld !== vld_exp || rsp_pa !== exp_pa || rsp_fault !== exp_fault
            || rsp_uncached !== exp_unc) begin
            errors++;
            $display("FAIL %s vld=%0b/%0b pa=%h/%h fault=%0d/%0d unc=%0b/%0b", tag,
                     rsp_vld, vld_exp, rsp_pa, exp_pa, rsp_fault, exp_fault,
                     rsp_uncached, exp_unc);
        end
    endtask

    task automatic req(input string tag, input logic [63:0] va, input logic ph,
                       input logic [1:0] md, input logic h, input logic [31:0] pp,
                       input logic [3:0] xr);
        req_vld = 1'b1; req_va = va; req_phys = ph; req_mode = md;
        req_asn = va[20:13] ^ 8'h5A; tlb_hit = h; tlb_ppn = pp; tlb_xre = xr;
        model(va, ph, md, h, pp, xr);
        #1;
        checks++;
        if (tlb_vpn !== va[47:13] || tlb_asn !== req_asn) begin
            errors++;
            $display("FAIL R6 key vpn=%h/%h asn=%h/%h", tlb_vpn, va[47:13], tlb_asn, req_asn);
        end
        @(negedge clk);
        compare(tag, 1'b1);
    endtask

    task automatic idle();
        req_vld = 1'b0;
        req_va = 64'h0000_0000_0000_0001;
        @(negedge clk);
        compare("R1 hold", 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (rsp_vld !== 1'b0 || rsp_pa !== '0 || rsp_fault !== 2'd0 || rsp_uncached !== 1'b0) begin
            errors++;
            $display("FAIL R11 vld=%0b pa=%h fault=%0d unc=%0b exp all 0",
                     rsp_vld, rsp_pa, rsp_fault, rsp_uncached);
        end
        rst_n = 1'b1;
        @(negedge clk);

        req("R2 bypass", 64'hFFFF_FFFF_FFFF_FFFD, 1'b1, 2'd3, 1'b0, 32'h0, 4'h0);
        req("R2 bypass window", 64'hFFFF_FC00_0000_1003, 1'b0, 2'd3, 1'b0, 32'h0, 4'h0);
        idle();
        req("R3 phys", 64'h0000_0123_4567_8ABC, 1'b1, 2'd3, 1'b0, 32'h0, 4'h0);
        req("R3 R10 phys uncached", 64'h0000_0800_0FFF_FFF8, 1'b1, 2'd2, 1'b0, 32'h0, 4'h0);
        req("R9 phys mchk", 64'h0000_1000_0000_0000, 1'b1, 2'd0, 1'b0, 32'h0, 4'h0);
        req("R4 noncanon", 64'h0001_0000_0000_0000, 1'b0, 2'd0, 1'b1, 32'h1, 4'hF);
        req("R4 noncanon hi", 64'h7FFF_8000_0000_0000, 1'b0, 2'd0, 1'b1, 32'h1, 4'hF);
        req("R5 direct kernel", 64'hFFFF_FC00_0000_1000, 1'b0, 2'd0, 1'b0, 32'h0, 4'h0);
        req("R5 direct user", 64'hFFFF_FC00_0000_1000, 1'b0, 2'd3, 1'b1, 32'h3, 4'hF);
        req("R5 R10 direct bit40", 64'hFFFF_FD00_0000_2000, 1'b0, 2'd0, 1'b0, 32'h0, 4'h0);
        req("R6 miss", 64'hFFFF_8000_0000_4000, 1'b0, 2'd0, 1'b0, 32'h7, 4'hF);
        req("R6 miss over perm", 64'h0000_0000_0040_2000, 1'b0, 2'd3, 1'b0, 32'h7, 4'h0);
        req("R7 hit", 64'h0000_0000_0040_1ABF, 1'b0, 2'd0, 1'b1, 32'h0001_2345, 4'h1);
        idle();
        for (int m = 0; m < 4; m++) begin
            req("R8 perm deny", 64'h0000_0000_0080_0010, 1'b0, 2'(m), 1'b1, 32'h55, 4'hF ^ (4'h1 << m));
            req("R8 perm allow", 64'h0000_0000_0080_0010, 1'b0, 2'(m), 1'b1, 32'h55, 4'h1 << m);
        end
        req("R9 mapped mchk", 64'h0000_0000_0000_0100, 1'b0, 2'd0, 1'b1, 32'h8000_0000, 4'h1);
        req("R10 mapped uncached", 64'h0000_0000_0000_0104, 1'b0, 2'd0, 1'b1, 32'h4000_0FFF, 4'h1);

        for (int i = 0; i < 3000; i++) begin
            logic [63:0] va;
            logic [31:0] pp;
            int kind;
            kind = $urandom_range(0, 6);
            va = {$urandom, $urandom};
            case (kind)
                0: va[0] = 1'b1;
                1: va[0] = 1'b0;
                2: begin va[0] = 1'b0; va[63:47] = 17'h1FFFF; va[46:41] = 6'h3E; end
                default: begin va[0] = 1'b0; va[63:47] = {17{va[47]}}; end
            endcase
            pp = $urandom;
            if ($urandom_range(0, 3) != 0) pp[31:31] = 1'b0;
            if ($urandom_range(0, 1) != 0) pp[30:28] = 3'b000;
            if ($urandom_range(0, 7) == 0) idle();
            req("R7 R8 R9 R10 random", va, kind == 1 ? 1'b1 : 1'b0, 2'($urandom_range(0, 3)),
                1'($urandom_range(0, 4) != 0), pp, 4'($urandom));
        end
        idle();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule